// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces periodic refresh for a DRAM controller. It divides the controller clock down to the average refresh interval and, at each interval boundary, adds one refresh to a small debt counter. While any refresh is owed it requests service from the downstream command scheduler. Each accepted grant pays back one refresh and starts a blocking window as long as the refresh cycle time of the attached device density. During that window the command path must stay quiet.

A case-temperature flag halves the interval for hot operation. The new interval takes effect only when the running interval ends, so the period in progress is never cut short. The debt counter lets the scheduler postpone up to eight refreshes. An urgent flag tells it when no more postponement is possible.

Interval and blocking times are given in picoseconds and turned into clock counts at elaboration, rounded up, from a clock-period parameter.

Top module: `refresh_sched`

## Requirements
- R1: During and directly after reset, the request, urgent and busy outputs are all low, and no refresh is owed.
- R2: With the hot flag low, a refresh is added every ceil(7.8 us / clock period) cycles. At the default 5000 ps period this is 1560 cycles. After reset is released the first one shows as a request after exactly 1560 rising edges.
- R3: With the hot flag high, the interval is ceil(3.9 us / clock period) cycles, which is 780 at the default period.
- R4: A change of the hot flag does not alter the interval already running. The counter reloads from the flag's value only at the next interval boundary.
- R5: The request output stays high for as long as at least one refresh is owed. A grant is accepted only when it is high while the request is high and busy is low, and an accepted grant pays back exactly one refresh.
- R6: At most 8 refreshes are owed. Urgent is high exactly when 8 are owed, and a boundary that arrives while 8 are owed adds nothing.
- R7: An accepted grant drives busy high from the next cycle for ceil(tRFC / clock period) cycles, with the density code sampled at the grant. The codes are 0 = 256Mb (75 ns), 1 = 512Mb (105 ns), 2 = 1Gb (127.5 ns), 3 = 2Gb (195 ns), and 4 to 7 = 4Gb (327.5 ns). At the default period these give 15, 21, 26, 39 and 66 cycles.
- R8: A grant while busy is high, or while nothing is owed, is ignored. It starts no busy window and pays back no refresh.
- R9: An interval boundary in the same cycle as an accepted grant leaves the owed count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Case temperature above 85 C; selects the halved interval |
| density_i | input | 3 | Device density code, sampled on an accepted grant |
| grant_i | input | 1 | Downstream scheduler issues the refresh this cycle |
| ref_req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | The owed count has reached its limit of 8 |
| busy_o | output | 1 | Refresh cycle time still running; hold other commands |

## Verification
A wrong interval counter shows up as a request edge that moves away from the exact expected cycle. The bench checks the cycle before and the cycle of every boundary, so a one-cycle drift is caught at the first boundary. A hot-flag change that reloads the counter mid-count moves the next request many hundreds of cycles early. A miscounted owed total shows up after the saturating sequence: either the request drops before the eighth grant or it survives it. This is visible within a few hundred cycles of the grants. A wrong density entry changes the measured busy length directly on the grant that uses it.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    // Density codes for the attached devices
    typedef enum logic [2:0] {
        DENS_256M = 3'd0,
        DENS_512M = 3'd1,
        DENS_1G   = 3'd2,
        DENS_2G   = 3'd3,
        DENS_4G   = 3'd4
    } density_e;

    localparam int unsigned DENS_W = 3;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Refresh cycle time in picoseconds; codes beyond the largest density use it
    function automatic int unsigned trfc_ps(input int unsigned code);
        case (code)
            0:       return 75000;
            1:       return 105000;
            2:       return 127500;
            3:       return 195000;
            default: return 327500;
        endcase
    endfunction

endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
    parameter int unsigned CLK_PS  = 5000,
    parameter int unsigned REFI_PS = 7800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot_i,
    output logic tick_o
);
    localparam int unsigned NORM_CYC = refsch_pkg::ceil_div(REFI_PS, CLK_PS);
    localparam int unsigned HOT_CYC  = refsch_pkg::ceil_div(REFI_PS, 2 * CLK_PS);
    localparam int unsigned CNT_W    = (NORM_CYC > 1) ? $clog2(NORM_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ivl_t;

    ivl_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (st_q.cnt == '0) begin
            tick_o   = 1'b1;
            // reload only at the boundary, from the flag's present value
            st_d.cnt = hot_i ? CNT_W'(HOT_CYC - 1) : CNT_W'(NORM_CYC - 1);
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: CNT_W'(NORM_CYC - 1)};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
    parameter int unsigned MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic take_i,
    output logic owed_o,
    output logic full_o
);
    localparam int unsigned DEBT_W = $clog2(MAX_DEBT + 1);

    typedef struct packed {
        logic [DEBT_W-1:0] cnt;
    } debt_t;

    debt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({tick_i, take_i})
            2'b10: if (st_q.cnt != DEBT_W'(MAX_DEBT)) st_d.cnt = st_q.cnt + 1'b1;
            2'b01: st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;   // idle, or boundary and payment cancel
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owed_o = (st_q.cnt != '0);
    assign full_o = (st_q.cnt == DEBT_W'(MAX_DEBT));

endmodule

// File: rtl/refsch_block.sv
module refsch_block #(
    parameter int unsigned CLK_PS = 5000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_i,
    input  logic [refsch_pkg::DENS_W-1:0] density_i,
    output logic                          busy_o
);
    localparam int unsigned NCODES  = 1 << refsch_pkg::DENS_W;
    localparam int unsigned MAX_CYC = refsch_pkg::ceil_div(refsch_pkg::trfc_ps(NCODES - 1), CLK_PS);
    localparam int unsigned BLK_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [BLK_W-1:0] cnt;
    } blk_t;

    blk_t             st_d, st_q;
    logic [BLK_W-1:0] lut [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_lut
        assign lut[g] = BLK_W'(refsch_pkg::ceil_div(refsch_pkg::trfc_ps(g), CLK_PS));
    end

    always_comb begin
        st_d = st_q;
        if (take_i)             st_d.cnt = lut[density_i];
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned CLK_PERIOD_PS = 5000,
    parameter int unsigned REFI_NORM_PS  = 7800000,
    parameter int unsigned MAX_DEBT      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hot_i,
    input  logic [2:0] density_i,
    input  logic       grant_i,
    output logic       ref_req_o,
    output logic       urgent_o,
    output logic       busy_o
);
    logic tick, take, owed, full, busy;

    // a grant counts only when something is owed and the window is closed
    assign take = grant_i & owed & ~busy;

    refsch_interval #(.CLK_PS(CLK_PERIOD_PS), .REFI_PS(REFI_NORM_PS)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .hot_i (hot_i),
        .tick_o(tick)
    );

    refsch_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .take_i(take),
        .owed_o(owed),
        .full_o(full)
    );

    refsch_block #(.CLK_PS(CLK_PERIOD_PS)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .density_i(density_i),
        .busy_o   (busy)
    );

    assign ref_req_o = owed;
    assign urgent_o  = full;
    assign busy_o    = busy;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int unsigned CLK_PERIOD_PS = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic ref_req_o,
    input logic urgent_o,
    input logic busy_o
);
    localparam int unsigned MIN_BLK = refsch_pkg::ceil_div(refsch_pkg::trfc_ps(0), CLK_PERIOD_PS);
    localparam int unsigned MAX_BLK = refsch_pkg::ceil_div(refsch_pkg::trfc_ps(7), CLK_PERIOD_PS);

    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R5: owed count only falls after an accepted grant
    p_req_drop_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req_o) |-> $past(grant_i && !busy_o));

    // R6: the limit can only be reached while a request is up
    p_urgent_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |-> ref_req_o);

    // R8: a window opens only on a grant with something owed
    p_busy_needs_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(grant_i && ref_req_o));

    // R7: every window lasts within the table's range
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q >= 16'(MIN_BLK) && run_q <= 16'(MAX_BLK)));

endmodule

bind refresh_sched refresh_sched_chk #(.CLK_PERIOD_PS(CLK_PERIOD_PS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_i  (grant_i),
    .ref_req_o(ref_req_o),
    .urgent_o (urgent_o),
    .busy_o   (busy_o)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
    localparam real CLK_NS = 5.0;
    localparam int  N = 1560;   // normal interval at 5000 ps
    localparam int  H = 780;    // hot interval
    localparam int  NV = 8;
    localparam int  VEC_DENS [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int  VEC_CYC  [NV] = '{15, 21, 26, 39, 66, 66, 66, 66};

    logic       clk = 1'b0, rst_n = 1'b0, hot = 1'b0, grant = 1'b0;
    logic [2:0] dens = 3'd0;
    logic       req, urg, busy;
    int         cyc, n_run = 0, n_fail = 0;

    refresh_sched u_dut (
        .clk(clk), .rst_n(rst_n), .hot_i(hot), .density_i(dens),
        .grant_i(grant), .ref_req_o(req), .urgent_o(urg), .busy_o(busy)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 req in reset", int'(req), 0);
        rst_n = 1'b1;
        check("R1 req", int'(req), 0);
        check("R1 urgent", int'(urg), 0);
        check("R1 busy", int'(busy), 0);
        grant = 1'b1;
        step();
        grant = 1'b0;
        check("R8 grant with no debt busy", int'(busy), 0);

        wait_to(N - 1);
        check("R2 req before first boundary", int'(req), 0);
        step();
        check("R2 req at first boundary", int'(req), 1);

        wait_to(8 * N - 1);
        check("R6 urgent at 7 owed", int'(urg), 0);
        step();
        check("R6 urgent at 8 owed", int'(urg), 1);
        wait_to(9 * N);
        check("R6 urgent after saturating boundary", int'(urg), 1);

        // density table walk: each entry pays one refresh, with a stray grant mid-window
        for (int i = 0; i < NV; i++) begin
            int n;
            dens  = 3'(VEC_DENS[i]);
            grant = 1'b1;
            step();
            grant = 1'b0;
            n = 0;
            while (busy && n < 1000) begin
                n++;
                grant = (n == 2);
                step();
            end
            grant = 1'b0;
            check($sformatf("R7 busy length code %0d", VEC_DENS[i]), n, VEC_CYC[i]);
            if (i == 0) check("R6 urgent after one payment", int'(urg), 0);
            check($sformatf("R5 R8 req after payment %0d", i + 1), int'(req), (i < NV - 1) ? 1 : 0);
        end

        hot = 1'b1;
        wait_to(10 * N - 1);
        check("R4 no early boundary after hot set", int'(req), 0);
        step();
        check("R4 boundary on old interval", int'(req), 1);
        dens  = 3'd0;
        grant = 1'b1;
        step();
        grant = 1'b0;
        check("R5 req cleared by grant", int'(req), 0);
        wait_to(10 * N + H - 1);
        check("R3 req before hot boundary", int'(req), 0);
        step();
        check("R3 req at hot boundary", int'(req), 1);

        wait_to(10 * N + H + 5);
        hot = 1'b0;
        wait_to(10 * N + 2 * H - 1);
        grant = 1'b1;
        step();
        grant = 1'b0;
        check("R9 busy on coincident grant", int'(busy), 1);
        check("R9 req on coincident grant", int'(req), 1);
        wait_to(10 * N + 2 * H + 20);
        check("R7 busy closed", int'(busy), 0);
        grant = 1'b1;
        step();
        grant = 1'b0;
        check("R9 exactly one owed after coincidence", int'(req), 0);

        wait_to(10 * N + 2 * H + N - 1);
        check("R4 req before cool boundary", int'(req), 0);
        step();
        check("R4 req at cool boundary", int'(req), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule